// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that carry a two-bit type tag in their least significant bits. Besides the 64-bit result it produces two sets of condition codes, one for the low 32-bit word and one for the full 64-bit word. The 32-bit overflow flag has a widened meaning: it is set both when the low word overflows as a signed number and when either operand has a nonzero tag. The 64-bit overflow flag keeps its ordinary meaning.

A trap-enable input selects the trapping form of the operation. With trapping enabled and a tag overflow present, the unit raises a tag-overflow trap request. In that case the registered result and both condition-code sets keep their previous values, so nothing downstream sees a partial update. Every input set is taken at a rising clock edge, and its outputs appear one cycle later.

Top module: `tagged_addsub`

## Requirements
- R1: While reset is asserted, and after its release until the first operation, `result` is 0, `icc` and `xcc` are both 4'b0100 (only Z set), and `tag_trap` is 0.
- R2: Inputs sampled at a rising edge show up on the outputs after that edge. `op_sub`=0 gives `result` = A + B mod 2^64, and `op_sub`=1 gives `result` = A − B mod 2^64.
- R3: A tag overflow exists when A[1:0] is nonzero, when B[1:0] is nonzero, or when the low 32 bits overflow as signed numbers. For addition that means equal sign bits [31] and a result bit [31] that differs from them. For subtraction it means differing sign bits [31] and a result bit [31] that differs from A[31].
- R4: Flag vectors are packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. `icc` bit 1 equals the tag overflow condition. `xcc` bit 1 is ordinary 64-bit signed overflow, judged on bit 63 with the same add and subtract rules.
- R5: `icc` bit 0 is the carry out of bit 31 for addition, or the borrow out of bit 31 for subtraction (set when A[31:0] < B[31:0] unsigned). `xcc` bit 0 is the carry or borrow out of bit 63.
- R6: `icc` N is result bit 31 and its Z is set when result[31:0] is zero. `xcc` N is result bit 63 and its Z is set when all 64 result bits are zero.
- R7: When `trap_en`=1 and a tag overflow exists, `tag_trap` is 1 in the next cycle and `result`, `icc` and `xcc` keep their previous values. This also holds for several such cycles in a row.
- R8: `tag_trap` is 0 after any cycle with `trap_en`=0, or with `trap_en`=1 and no tag overflow. Those cycles update `result` and the flags normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | First operand (minuend for subtraction) |
| op_b | input | 64 | Second operand (subtrahend for subtraction) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| trap_en | input | 1 | Selects the trapping form of the operation |
| result | output | 64 | Registered sum or difference |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C} |
| tag_trap | output | 1 | Tag-overflow trap request |

## Verification
The operand patterns are chosen so that each flag source can be told apart from the others:
- Clean tags with small values show the plain sum and difference.
- A tag in only A, or only B, proves that either tag alone drives `icc` V.
- Sign-boundary values near 2^31 overflow the low word but not the full word.
- Values near 2^63 overflow only the full word.
- A wrap to zero, and a difference that goes negative, exercise both carries and borrows and both Z flags.

Trapping cases use tag-only and overflow-only triggers, including back-to-back trapping cycles, to show that the held outputs are truly frozen. A following clean operation shows that updating resumes.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;

    // Condition-code group, packed so that n lands at bit 3 and c at bit 0.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    // Signed overflow from sign bits: sb_eff is the sign of the operand as
    // actually fed to the adder (inverted for subtraction).
    function automatic logic signed_ovf(input logic sa, input logic sb_eff, input logic sr);
        return (sa == sb_eff) && (sr != sa);
    endfunction

endpackage

// File: rtl/tagalu_adder.sv
module tagalu_adder #(
    parameter int unsigned W     = 64,
    parameter int unsigned SPLIT = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         co_lo,
    output logic         co_hi,
    output logic         bs_lo,
    output logic         bs_hi
);
    localparam int unsigned HI_W = W - SPLIT;

    logic [W-1:0]    b_eff;
    logic [SPLIT:0]  seg_lo;
    logic [HI_W:0]   seg_hi;

    // Two chained segments so the carry at the lane boundary is a real wire.
    always_comb begin
        b_eff  = sub ? ~b : b;
        seg_lo = {1'b0, a[SPLIT-1:0]} + {1'b0, b_eff[SPLIT-1:0]}
               + {{SPLIT{1'b0}}, sub};
        seg_hi = {1'b0, a[W-1:SPLIT]} + {1'b0, b_eff[W-1:SPLIT]}
               + {{HI_W{1'b0}}, seg_lo[SPLIT]};
        sum    = {seg_hi[HI_W-1:0], seg_lo[SPLIT-1:0]};
        co_lo  = seg_lo[SPLIT];
        co_hi  = seg_hi[HI_W];
        bs_lo  = b_eff[SPLIT-1];
        bs_hi  = b_eff[W-1];
    end

endmodule

// File: rtl/tagalu_flags.sv
module tagalu_flags
    import tagalu_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned SPLIT = 32,
    parameter int unsigned TAG_W = 2
) (
    input  logic [TAG_W-1:0] a_tag,
    input  logic [TAG_W-1:0] b_tag,
    input  logic             a_sign_lo,
    input  logic             a_sign_hi,
    input  logic             bs_lo,
    input  logic             bs_hi,
    input  logic [W-1:0]     sum,
    input  logic             co_lo,
    input  logic             co_hi,
    input  logic             sub,
    output cc_t              icc,
    output cc_t              xcc,
    output logic             tag_ovf
);
    logic v_lo;
    logic v_hi;

    always_comb begin
        v_lo    = signed_ovf(a_sign_lo, bs_lo, sum[SPLIT-1]);
        v_hi    = signed_ovf(a_sign_hi, bs_hi, sum[W-1]);
        tag_ovf = (|a_tag) || (|b_tag) || v_lo;

        icc.n = sum[SPLIT-1];
        icc.z = (sum[SPLIT-1:0] == '0);
        icc.v = tag_ovf;
        icc.c = co_lo ^ sub;   // adder carry inverted into a borrow on subtract

        xcc.n = sum[W-1];
        xcc.z = (sum == '0);
        xcc.v = v_hi;
        xcc.c = co_hi ^ sub;

        // R3: a nonzero tag on either operand always flags a tag overflow
        if (|a_tag) begin
            assert_tag_from_a_R3: assert (tag_ovf);
        end
        if (|b_tag) begin
            assert_tag_from_b_R3: assert (tag_ovf);
        end
    end

endmodule

// File: rtl/tagged_addsub.sv
module tagged_addsub
    import tagalu_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 32,
    parameter int unsigned TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              trap_en,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        icc,
    output logic [3:0]        xcc,
    output logic              tag_trap
);
    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        cc_t               icc;
        cc_t               xcc;
        logic              trap;
    } state_t;

    state_t     st_d;
    state_t     st_q;
    addsub_op_e op_kind;

    logic [DATA_W-1:0] sum_w;
    logic              co_lo_w;
    logic              co_hi_w;
    logic              bs_lo_w;
    logic              bs_hi_w;
    cc_t               icc_w;
    cc_t               xcc_w;
    logic              tag_ovf_w;

    assign op_kind = addsub_op_e'(op_sub);

    tagalu_adder #(
        .W     (DATA_W),
        .SPLIT (LANE_W)
    ) u_adder (
        .a     (op_a),
        .b     (op_b),
        .sub   (op_kind == OP_SUB),
        .sum   (sum_w),
        .co_lo (co_lo_w),
        .co_hi (co_hi_w),
        .bs_lo (bs_lo_w),
        .bs_hi (bs_hi_w)
    );

    tagalu_flags #(
        .W     (DATA_W),
        .SPLIT (LANE_W),
        .TAG_W (TAG_W)
    ) u_flags (
        .a_tag     (op_a[TAG_W-1:0]),
        .b_tag     (op_b[TAG_W-1:0]),
        .a_sign_lo (op_a[LANE_W-1]),
        .a_sign_hi (op_a[DATA_W-1]),
        .bs_lo     (bs_lo_w),
        .bs_hi     (bs_hi_w),
        .sum       (sum_w),
        .co_lo     (co_lo_w),
        .co_hi     (co_hi_w),
        .sub       (op_kind == OP_SUB),
        .icc       (icc_w),
        .xcc       (xcc_w),
        .tag_ovf   (tag_ovf_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (trap_en && tag_ovf_w) begin
            st_d.trap = 1'b1;            // faulting form: destination and flags frozen
        end else begin
            st_d.res = sum_w;
            st_d.icc = icc_w;
            st_d.xcc = xcc_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{res: '0, icc: CC_RESET, xcc: CC_RESET, trap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.res;
    assign icc      = st_q.icc;
    assign xcc      = st_q.xcc;
    assign tag_trap = st_q.trap;

    // R7: a faulting cycle requests the trap and leaves every output frozen
    assert_trap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && tag_ovf_w) |=> (tag_trap && $stable(result) && $stable(icc) && $stable(xcc)));

    // R8: no trap request can follow a cycle with trapping disabled
    assert_no_trap_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en |=> !tag_trap);

    // R4: a tagged operand in a non-trapping cycle sets the 32-bit V flag
    assert_tag_sets_v_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_en && ((op_a[TAG_W-1:0] != '0) || (op_b[TAG_W-1:0] != '0))) |=> icc[1]);

    // R6: N and Z always agree with the result they describe
    assert_nz_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (icc[2] == (result[LANE_W-1:0] == '0)) && (xcc[2] == (result == '0))
        && (icc[3] == result[LANE_W-1]) && (xcc[3] == result[DATA_W-1]));

endmodule

// File: tb/tagged_addsub_tb.sv
`timescale 1ns/1ps
module tagged_addsub_tb;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic        sub;
        logic        te;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0000_0004, 64'h0000_0000_0000_0008, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0004, 64'h0000_0000_0000_0002, 1'b0, 1'b0},
        '{64'h0000_0000_7FFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0008, 64'h0000_0000_0000_0004, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0004, 64'h0000_0000_0000_0008, 1'b1, 1'b0},
        '{64'h0000_0000_8000_0000, 64'h0000_0000_0000_0004, 1'b1, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
        '{64'h7FFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
        '{64'h8000_0000_0000_0000, 64'h0000_0000_0000_0004, 1'b1, 1'b0},
        '{64'h0000_0000_FFFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 1'b0, 1'b1},
        '{64'h0000_0000_0000_0013, 64'h0000_0000_0000_0020, 1'b0, 1'b1},
        '{64'h0000_0000_7FFF_FFF0, 64'h0000_0000_0000_0010, 1'b0, 1'b1},
        '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0040, 1'b1, 1'b1},
        '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0003, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic        op_sub;
    logic        trap_en;
    logic [63:0] result;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    logic        tag_trap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_res = 64'h0;
    logic [3:0]  exp_icc = 4'b0100;
    logic [3:0]  exp_xcc = 4'b0100;

    always #2.5 clk = ~clk;

    tagged_addsub u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_sub   (op_sub),
        .trap_en  (trap_en),
        .result   (result),
        .icc      (icc),
        .xcc      (xcc),
        .tag_trap (tag_trap)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference built from the requirement text using widened signed arithmetic.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic sub,
                         output logic [63:0] r, output logic [3:0] ic,
                         output logic [3:0] xc, output logic tag);
        logic signed [32:0] s32;
        logic signed [64:0] s64;
        logic c32, c64, v32, v64;
        logic [64:0] w;
        logic [32:0] w32;
        if (sub) begin
            w   = {1'b0, a} - {1'b0, b};
            c32 = (a[31:0] < b[31:0]);
            c64 = (a < b);
            s32 = $signed({a[31], a[31:0]}) - $signed({b[31], b[31:0]});
            s64 = $signed({a[63], a}) - $signed({b[63], b});
        end else begin
            w   = {1'b0, a} + {1'b0, b};
            w32 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
            c32 = w32[32];
            c64 = w[64];
            s32 = $signed({a[31], a[31:0]}) + $signed({b[31], b[31:0]});
            s64 = $signed({a[63], a}) + $signed({b[63], b});
        end
        r   = w[63:0];
        v32 = s32[32] ^ s32[31];
        v64 = s64[64] ^ s64[63];
        tag = (a[1:0] != 2'b00) || (b[1:0] != 2'b00) || v32;
        ic  = {r[31], (r[31:0] == 32'h0), tag, c32};
        xc  = {r[63], (r == 64'h0), v64, c64};
    endtask

    // Drive just after a falling edge; the result is registered at the next
    // rising edge and sampled at the falling edge after it.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic sub, input logic te);
        logic [63:0] r;
        logic [3:0]  ic, xc;
        logic        tag;
        op_a    = a;
        op_b    = b;
        op_sub  = sub;
        trap_en = te;
        model(a, b, sub, r, ic, xc, tag);
        @(negedge clk);
        if (te && tag) begin
            chk("R7 trap request", {63'h0, tag_trap}, 64'h1);
            chk("R7 result held", result, exp_res);
            chk("R7 icc held", {60'h0, icc}, {60'h0, exp_icc});
            chk("R7 xcc held", {60'h0, xcc}, {60'h0, exp_xcc});
        end else begin
            exp_res = r;
            exp_icc = ic;
            exp_xcc = xc;
            chk("R2 result", result, r);
            chk("R3 R4 icc V", {63'h0, icc[1]}, {63'h0, tag});
            chk("R4 R5 R6 icc", {60'h0, icc}, {60'h0, ic});
            chk("R4 R5 R6 xcc", {60'h0, xcc}, {60'h0, xc});
            chk("R8 no trap", {63'h0, tag_trap}, 64'h0);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        op_a    = 64'h0;
        op_b    = 64'h0;
        op_sub  = 1'b0;
        trap_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", result, 64'h0);
        chk("R1 icc", {60'h0, icc}, 64'h4);
        chk("R1 xcc", {60'h0, xcc}, 64'h4);
        chk("R1 trap", {63'h0, tag_trap}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 held after release", result, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].te);
        end

        // R7: back-to-back trapping cycles, tag in B then 32-bit overflow only
        run_op(64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 1'b0, 1'b1);
        run_op(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0010, 1'b1, 1'b1);
        // R8: trapping form with clean operands updates normally
        run_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4320, 1'b1, 1'b1);
        // R4: 64-bit overflow in the trapping form does not trap (xcc V only)
        run_op(64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 1'b1);

        // R1: reset applied mid-run returns the outputs to their reset values
        op_a  = 64'h0000_0000_0000_0003;
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run result", result, 64'h0);
        chk("R1 mid-run icc", {60'h0, icc}, 64'h4);
        chk("R1 mid-run trap", {63'h0, tag_trap}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_res = 64'h0;
        exp_icc = 4'b0100;
        exp_xcc = 4'b0100;
        run_op(64'h0000_0000_0000_0007, 64'h0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule